// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Holding Latch

This block collects a bit stream one bit at a time into an N-stage shift chain, and on command copies the whole chain into a separate holding register that drives an N-bit parallel bus. It has two strobes. The shift strobe advances the chain and the store strobe updates the bus, so the bus changes only when software or a controller asks for a transfer. The last chain stage is also brought out as a serial cascade output. Wiring that output to the serial input of a second copy builds a longer register.

Both strobes are treated as asynchronous events. Each one passes through a two-flop synchronizer and a rising-edge detector in the system clock domain. An active-low clear empties the shift chain and leaves the holding register alone. An active-low output enable gates the parallel bus and reports a per-bit drive-enable; it has no effect on the cascade output. High impedance is shown as a drive-enable of 0 with the bus value held at 0.

Top module: `serial_latch_shifter`

## Requirements
- R1: A shift event moves `ser_in` into stage 0 and moves each stage k up to stage k+1. `ser_out` always equals stage N-1, the stage that ends up furthest from `ser_in`.
- R2: A store event copies all N chain stages into the holding register at once. The holding register, and so `par_out`, changes at no other time except system reset.
- R3: When the two strobes produce events in the same clock, the holding register receives the chain contents from before that shift.
- R4: While `clear_n` is low, every chain stage reads 0 from the next clock edge on, so `ser_out` is 0. Shift events have no effect and the holding register keeps its value.
- R5: A store event that happens while `clear_n` is low loads all zeros into the holding register.
- R6: When `out_en_n` is 0, `par_drive` is all ones and `par_out` shows the holding register, with bit k holding stage k's captured value. When `out_en_n` is 1, `par_drive` and `par_out` are all zeros. `ser_out` never depends on `out_en_n`.
- R7: Two instances chained `ser_out` to `ser_in` that share the strobes behave as one 2N-stage register. The upstream instance's old stage N-1 enters the downstream stage 0.
- R8: Each low-to-high transition of a strobe gives exactly one event, however long the strobe stays high. The state change becomes visible after the third rising clock edge that sees the strobe high.
- R9: With `rst_n` low, the chain and the holding register are both all zeros.
- R10: After `clear_n` returns high, the next shift event is performed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| ser_in | input | 1 | Serial data entering stage 0 |
| shift_strobe | input | 1 | Asynchronous shift strobe, acts on its rising edge |
| store_strobe | input | 1 | Asynchronous transfer strobe, acts on its rising edge |
| clear_n | input | 1 | Active-low clear of the shift chain, sampled on the clock |
| out_en_n | input | 1 | Active-low parallel output enable |
| par_out | output | N | Parallel bus from the holding register, 0 when disabled |
| par_drive | output | N | Per-bit drive-enable, 1 means driven |
| ser_out | output | 1 | Cascade output, the last chain stage |

## Verification
A wrong chain bit is visible at `ser_out` only once it has moved up to stage N-1, which can take up to N-1 further shifts. It is visible on `par_out` after the next store event, so the bench always follows a shift sequence with a store and compares the whole bus. A missing or doubled edge detection shows up as a bus shifted by one position. Timing faults in the synchronizer show up in the cycle-exact latency check on `ser_out`. A clear that also wipes the holding register, or an enable that gates `ser_out`, appears at the ports in the first cycle after the stimulus.

// File: rtl/serial_latch_pkg.sv
package serial_latch_pkg;
  // index of each strobe in the synchronizer array
  typedef enum int unsigned { STB_SHIFT = 0, STB_STORE = 1 } strobe_idx_e;
  localparam int unsigned STROBE_COUNT = 2;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic event_pulse
);
  localparam int unsigned TAPS = SYNC_STAGES + 1;
  logic [TAPS-1:0] taps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= {taps_q[TAPS-2:0], strobe_async};
  end

  // last synced tap high, previous sample low
  assign event_pulse = taps_q[SYNC_STAGES-1] & ~taps_q[SYNC_STAGES];

  // R8: one event per rising edge
  no_double_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |=> !event_pulse);
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_n,
  input  logic         shift_ev,
  input  logic         ser_in,
  output logic [N-1:0] stages,
  output logic         ser_out
);
  logic [N-1:0] stages_q;

  function automatic logic [N-1:0] advance(input logic [N-1:0] cur, input logic b);
    return {cur[N-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stages_q <= '0;
    else if (!clear_n) stages_q <= '0;
    else if (shift_ev) stages_q <= advance(stages_q, ser_in);
  end

  assign stages  = stages_q;
  assign ser_out = stages_q[N-1];

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (stages == '0));
  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && clear_n) |=> (stages[0] == $past(ser_in)) && (stages[N-1:1] == $past(stages[N-2:0])));
  // R1 R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_ev && clear_n) |=> $stable(stages));
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         store_ev,
  input  logic [N-1:0] din,
  output logic [N-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held <= '0;
    else if (store_ev) held <= din;
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store_ev |=> $stable(held));
  // R3 R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_ev |=> (held == $past(din)));
endmodule

// File: rtl/serial_latch_shifter.sv
module serial_latch_shifter
  import serial_latch_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         shift_strobe,
  input  logic         store_strobe,
  input  logic         clear_n,
  input  logic         out_en_n,
  output logic [N-1:0] par_out,
  output logic [N-1:0] par_drive,
  output logic         ser_out
);
  logic [STROBE_COUNT-1:0] strobe_raw;
  logic [STROBE_COUNT-1:0] strobe_ev;
  logic [N-1:0]            chain_bits;
  logic [N-1:0]            held_bits;

  assign strobe_raw[STB_SHIFT] = shift_strobe;
  assign strobe_raw[STB_STORE] = store_strobe;

  for (genvar g = 0; g < STROBE_COUNT; g++) begin : g_sync
    strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n),
      .strobe_async(strobe_raw[g]),
      .event_pulse(strobe_ev[g])
    );
  end

  shift_chain #(.N(N)) u_chain (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n),
    .shift_ev(strobe_ev[STB_SHIFT]), .ser_in(ser_in),
    .stages(chain_bits), .ser_out(ser_out)
  );

  hold_reg #(.N(N)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .store_ev(strobe_ev[STB_STORE]),
    .din(chain_bits), .held(held_bits)
  );

  assign par_drive = {N{~out_en_n}};
  assign par_out   = held_bits & par_drive;

  // R6
  cascade_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out == chain_bits[N-1]);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (chain_bits == '0) && (held_bits == '0));
endmodule

// File: tb/test_serial_latch_shifter.sv
module test_serial_latch_shifter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, ser_in, sh_stb, st_stb, clr_n, oe_n;
  logic [W-1:0] par_a, drv_a, par_b, drv_b;
  logic so_a, so_b;
  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side reference state
  logic [W-1:0] m_stg_a, m_stg_b, m_hold_a, m_hold_b;

  always #5 clk = ~clk;

  serial_latch_shifter #(.N(W)) i_serial_latch_shifter (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_strobe(sh_stb),
    .store_strobe(st_stb), .clear_n(clr_n), .out_en_n(oe_n),
    .par_out(par_a), .par_drive(drv_a), .ser_out(so_a));

  serial_latch_shifter #(.N(W)) i_serial_latch_shifter_tail (
    .clk(clk), .rst_n(rst_n), .ser_in(so_a), .shift_strobe(sh_stb),
    .store_strobe(st_stb), .clear_n(clr_n), .out_en_n(oe_n),
    .par_out(par_b), .par_drive(drv_b), .ser_out(so_b));

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  // one strobe cycle: high for 3 clocks then low for 3
  task automatic strobe(logic do_sh, logic do_st, logic b);
    ser_in = b; sh_stb = do_sh; st_stb = do_st;
    ticks(3);
    sh_stb = 0; st_stb = 0;
    ticks(3);
    if (do_st) begin m_hold_a = m_stg_a; m_hold_b = m_stg_b; end
    if (do_sh && clr_n) begin
      m_stg_b = {m_stg_b[W-2:0], m_stg_a[W-1]};
      m_stg_a = {m_stg_a[W-2:0], b};
    end
  endtask

  task automatic check_bus(string tag);
    chk({tag, " par_a"}, par_a, oe_n ? '0 : m_hold_a);
    chk({tag, " drv_a"}, drv_a, oe_n ? '0 : '1);
    chk({tag, " ser_a"}, W'(so_a), W'(m_stg_a[W-1]));
    chk({tag, " par_b"}, par_b, oe_n ? '0 : m_hold_b);
  endtask

  // {simultaneous store on last bit, out_en_n, data byte sent MSB first}
  localparam logic [9:0] VEC [6] = '{
    10'b0_0_10110011, 10'b1_0_01011100, 10'b0_1_11110000,
    10'b1_0_00000001, 10'b0_0_11111111, 10'b1_0_10000000 };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ser_in = 0; sh_stb = 0; st_stb = 0; clr_n = 1; oe_n = 0;
    m_stg_a = '0; m_stg_b = '0; m_hold_a = '0; m_hold_b = '0;
    ticks(3);
    // R9 reset state
    check_bus("R9 reset");
    rst_n = 1;
    ticks(2);

    // R1 R2 R3 R6 R7: table walk
    foreach (VEC[i]) begin
      oe_n = VEC[i][8];
      for (int k = W - 1; k >= 0; k--) begin
        if (k == 0 && VEC[i][9]) strobe(1, 1, VEC[i][k]);
        else                     strobe(1, 0, VEC[i][k]);
      end
      if (!VEC[i][9]) strobe(0, 1, 0);
      check_bus($sformatf("R1 R2 R3 R6 R7 vec%0d", i));
    end
    oe_n = 0;

    // R2: shifting alone leaves the bus untouched
    strobe(1, 0, 1); strobe(1, 0, 0);
    check_bus("R2 shift-only bus held");

    // R6: enable toggles bus but never ser_out
    oe_n = 1; ticks(1);
    check_bus("R6 disabled");
    oe_n = 0; ticks(1);
    check_bus("R6 re-enabled");

    // R4: clear empties chain, keeps holding register, blocks shifts
    clr_n = 0; ticks(1);
    m_stg_a = '0; m_stg_b = '0;
    check_bus("R4 clear");
    strobe(1, 0, 1);
    check_bus("R4 shift ignored");
    // R5: store while clear low
    strobe(0, 1, 0);
    check_bus("R5 store during clear");
    clr_n = 1; ticks(1);

    // R10: first shift after release is honoured
    strobe(1, 0, 1);
    for (int k = 0; k < W - 1; k++) strobe(1, 0, 0);
    check_bus("R10 post-clear shift");

    // R8 latency: chain holds 0..,1 at stage N-2 after clear and N-1 ones
    clr_n = 0; ticks(1); clr_n = 1;
    m_stg_a = '0; m_stg_b = '0;
    for (int k = 0; k < W - 1; k++) strobe(1, 0, 1);
    ser_in = 1; sh_stb = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 no change after two edges", W'(so_a), '0);
    @(posedge clk); #1;
    chk("R8 change after third edge", W'(so_a), W'(1));
    // long high: exactly one event
    ticks(12); sh_stb = 0; ticks(3);
    m_stg_b = {m_stg_b[W-2:0], m_stg_a[W-1]};
    m_stg_a = {m_stg_a[W-2:0], 1'b1};
    strobe(0, 1, 0);
    check_bus("R8 long strobe one event");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule